// File: doc/BRIEF.md
# SDR SDRAM Command-Bus Timing Monitor

This block watches the command pins of a single-data-rate SDRAM bus and never drives them. On every rising clock edge it decodes the command, keeps a small state machine per bank (open or closed, the row that was opened, and down-counters that track the minimum spacing to the next legal command), and compares each new command against those counters and against the open/closed state of the banks. A violation sets a sticky flag for its class and, if it is the first violation since reset, records its code.

It sits next to a memory controller, either in a simulation bench or in silicon as a protocol watchdog. All minimum spacings are parameters given in clock cycles. Data-bus contents, read-data latency and the low-power states are not examined. The monitor keeps tracking the bus after an error, and the command is applied to the tracked state even when it breaks a rule.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: A cycle with `cke` low or `cs_n` high decodes as DESEL (0). Otherwise {ras_n,cas_n,we_n} decodes 000 MRS (2), 001 REFRESH (3), 010 PRECHARGE (4), 011 ACTIVE (5), 100 WRITE (6), 101 READ (7), 110 BURST STOP (8), 111 NOP (1). `cmd_o` shows the code of the command sampled at the previous edge and is 0 after reset.
- R2: ACTIVE sets `bank_open_o[ba]`. PRECHARGE with `addr[10]` low clears only bank `ba`. PRECHARGE with `addr[10]` high clears every bank whatever `ba` is. READ or WRITE with `addr[10]` high (auto-precharge) clears bank `ba`. All banks are closed after reset.
- R3: ACTIVE stores `addr` as the row of bank `ba` in `open_row_o[ba*ADDR_W +: ADDR_W]`. The value is held until the next ACTIVE to that bank and is zero after reset.
- R4: Error code k sets `err_flags_o[k-1]`. The flags stay set until reset. `err_first_o` holds the code of the first error since reset (the lowest code when several arise in one cycle) and is 0 while no error has occurred.
- R5: Code 1: any command other than NOP or DESEL fewer than T_MRD (2) cycles after MRS.
- R6: Code 2: MRS or REFRESH while any bank is open.
- R7: Code 3: READ or WRITE to a bank fewer than T_RCD (2) cycles after its ACTIVE.
- R8: Code 4: PRECHARGE fewer than T_RAS (5) cycles after the ACTIVE of an open bank it targets. With `addr[10]` high, all open banks are checked.
- R9: Code 5: ACTIVE to a bank fewer than T_RP (2) cycles after a PRECHARGE that targeted it, or fewer than BURST_LEN+T_RP (6) cycles after an auto-precharge READ or WRITE to it.
- R10: Code 6: ACTIVE to a bank fewer than T_RC (7) cycles after that bank's previous ACTIVE.
- R11: Code 7: ACTIVE to a bank other than the last activated one, fewer than T_RRD (2) cycles after that last ACTIVE.
- R12: Code 8: READ or WRITE fewer than BURST_LEN (4) cycles after an auto-precharge READ or WRITE.
- R13: Code 9: READ, WRITE, or single-bank PRECHARGE to a closed bank. Code 10: ACTIVE to a bank that is already open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge sampled |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus; bit AP_BIT is the all-bank / auto-precharge bit |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_open_o | output | 2**BA_W | Open-bank bitmap |
| open_row_o | output | 2**BA_W*ADDR_W | Row last opened in each bank |
| err_flags_o | output | 10 | Sticky flag per error code |
| err_first_o | output | 4 | Code of first error since reset |

## Verification
The hardest case to reach is a command that breaks several rules at once while other banks are partway through their own timing windows. Examples are an ACTIVE issued into the tail of an auto-precharge window that also violates the row-cycle rule, or a precharge-all that meets a freshly opened bank among older ones. The stimulus reaches these cases with hand-ordered command sequences that issue each offending command on the exact cycle that a window still covers. A mid-run reset then separates these sequences from the earlier ones. A reference model in the bench works from absolute cycle stamps rather than counters, and the bench compares every output with it on every clock.

// File: rtl/sdrmon_pkg.sv
// Shared command and error encodings for the SDRAM command monitor.
package sdrmon_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_MRS   = 4'd2,
        CMD_REF   = 4'd3,
        CMD_PRE   = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_WR    = 4'd6,
        CMD_RD    = 4'd7,
        CMD_BST   = 4'd8
    } cmd_e;

    localparam int NUM_ERR = 10;

    typedef enum logic [3:0] {
        ERR_NONE    = 4'd0,
        ERR_MRD     = 4'd1,
        ERR_IDLE    = 4'd2,
        ERR_RCD     = 4'd3,
        ERR_RAS     = 4'd4,
        ERR_RP      = 4'd5,
        ERR_RC      = 4'd6,
        ERR_RRD     = 4'd7,
        ERR_APBUSY  = 4'd8,
        ERR_CLOSED  = 4'd9,
        ERR_REOPEN  = 4'd10
    } err_e;

endpackage

// File: rtl/sdrmon_decode.sv
// Command decoder.
// Turns the sampled control pins into a command code. Assumes the pins are
// already synchronous to clk. A cycle with clock enable low is treated as
// no command, because power-down tracking is not part of this block.
module sdrmon_decode
    import sdrmon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the strobe pattern to a command code.
    always_comb begin
        if (!cke || cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b010:  cmd = CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WR;
                3'b101:  cmd = CMD_RD;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdrmon_bank.sv
// Per-bank tracker.
// Holds the open flag and the open row of one bank, plus four down-counters
// that measure the minimum spacing from its last ACTIVE and last close. Each
// counter is loaded with (spacing - 1) on its event and counts down to zero.
// A nonzero counter means the matching command is still too early.
// Assumes at most one of act_i / pre_i / ap_i is high in a cycle and that
// every spacing parameter is at least 1.
module sdrmon_bank #(
    parameter int ADDR_W    = 12,
    parameter int CW        = 5,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 2,
    parameter int T_RC      = 7,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              pre_i,
    input  logic              ap_i,
    input  logic [ADDR_W-1:0] row_i,
    output logic              open_o,
    output logic [ADDR_W-1:0] row_o,
    output logic              rcd_busy_o,
    output logic              ras_busy_o,
    output logic              rp_busy_o,
    output logic              rc_busy_o
);

    localparam logic [CW-1:0] LD_RCD  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RAS  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] LD_RC   = CW'(T_RC - 1);
    localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_APRP = CW'(BURST_LEN + T_RP - 1);

    logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q;

    function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    // Open flag and captured row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (pre_i || ap_i) begin
            open_o <= 1'b0;
        end
    end

    // Spacing counters, loaded on their event, otherwise counting to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_q <= '0;
            ras_q <= '0;
            rc_q  <= '0;
            rp_q  <= '0;
        end else begin
            rcd_q <= act_i ? LD_RCD : step_down(rcd_q);
            ras_q <= act_i ? LD_RAS : step_down(ras_q);
            rc_q  <= act_i ? LD_RC  : step_down(rc_q);
            if (pre_i)
                rp_q <= LD_RP;
            else if (ap_i)
                rp_q <= LD_APRP;
            else
                rp_q <= step_down(rp_q);
        end
    end

    assign rcd_busy_o = (rcd_q != '0);
    assign ras_busy_o = (ras_q != '0);
    assign rc_busy_o  = (rc_q  != '0);
    assign rp_busy_o  = (rp_q  != '0);

endmodule

// File: rtl/sdrmon_track.sv
// Device-wide spacing tracker.
// Counts the mode-register settle window, the bank-to-bank activate window
// and the auto-precharge burst window. It also remembers which bank was
// activated last. Counters use the same load-(n-1)-and-count-down scheme as
// the per-bank tracker. Assumes every spacing parameter is at least 1.
module sdrmon_track #(
    parameter int BA_W      = 2,
    parameter int CW        = 5,
    parameter int T_MRD     = 2,
    parameter int T_RRD     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mrs_i,
    input  logic            act_i,
    input  logic            ap_i,
    input  logic [BA_W-1:0] ba_i,
    output logic            mrd_busy_o,
    output logic            rrd_busy_o,
    output logic            ap_busy_o,
    output logic [BA_W-1:0] last_ba_o
);

    localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 1);
    localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);
    localparam logic [CW-1:0] LD_AP  = CW'(BURST_LEN - 1);

    logic [CW-1:0] mrd_q, rrd_q, ap_q;

    function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    // Device-wide counters and last activated bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrd_q     <= '0;
            rrd_q     <= '0;
            ap_q      <= '0;
            last_ba_o <= '0;
        end else begin
            mrd_q <= mrs_i ? LD_MRD : step_down(mrd_q);
            rrd_q <= act_i ? LD_RRD : step_down(rrd_q);
            ap_q  <= ap_i  ? LD_AP  : step_down(ap_q);
            if (act_i)
                last_ba_o <= ba_i;
        end
    end

    assign mrd_busy_o = (mrd_q != '0);
    assign rrd_busy_o = (rrd_q != '0);
    assign ap_busy_o  = (ap_q  != '0);

endmodule

// File: rtl/sdr_cmd_monitor.sv
// SDR SDRAM command-bus timing monitor (top).
// A passive observer. It decodes each sampled command and updates the bank
// trackers. It then evaluates every protocol and spacing rule against the
// state before the command, and gathers violations into sticky flags plus a
// first-error code. Every output is registered, so an effect appears one edge
// after the command is sampled. Assumes spacings >= 1 and AP_BIT < ADDR_W.
module sdr_cmd_monitor
    import sdrmon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    parameter int T_MRD     = 2,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 2,
    parameter int T_RC      = 7,
    parameter int T_RRD     = 2,
    parameter int BURST_LEN = 4,
    localparam int NB       = 1 << BA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [3:0]           cmd_o,
    output logic [NB-1:0]        bank_open_o,
    output logic [NB*ADDR_W-1:0] open_row_o,
    output logic [NUM_ERR-1:0]   err_flags_o,
    output logic [3:0]           err_first_o
);

    localparam int CW = $clog2(T_MRD + T_RCD + T_RAS + T_RP + T_RC + T_RRD + BURST_LEN + 1);

    cmd_e cmd;
    logic is_mrs, is_ref, is_pre, is_act, is_rdwr, is_live, ap_bit;

    sdrmon_decode u_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign ap_bit  = addr[AP_BIT];
    assign is_mrs  = (cmd == CMD_MRS);
    assign is_ref  = (cmd == CMD_REF);
    assign is_pre  = (cmd == CMD_PRE);
    assign is_act  = (cmd == CMD_ACT);
    assign is_rdwr = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign is_live = (cmd != CMD_NOP) && (cmd != CMD_DESEL);

    logic [NB-1:0] open_v, rcd_b, ras_b, rp_b, rc_b;
    logic [NB-1:0] act_sel, pre_sel, ap_sel;

    // One tracker per bank; each sees only the events aimed at it.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [ADDR_W-1:0] row_q;

        assign act_sel[b] = is_act  && (ba == BA_W'(b));
        assign pre_sel[b] = is_pre  && (ap_bit || (ba == BA_W'(b)));
        assign ap_sel[b]  = is_rdwr && ap_bit && (ba == BA_W'(b));

        sdrmon_bank #(
            .ADDR_W    (ADDR_W),
            .CW        (CW),
            .T_RCD     (T_RCD),
            .T_RAS     (T_RAS),
            .T_RP      (T_RP),
            .T_RC      (T_RC),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_sel[b]),
            .pre_i      (pre_sel[b]),
            .ap_i       (ap_sel[b]),
            .row_i      (addr),
            .open_o     (open_v[b]),
            .row_o      (row_q),
            .rcd_busy_o (rcd_b[b]),
            .ras_busy_o (ras_b[b]),
            .rp_busy_o  (rp_b[b]),
            .rc_busy_o  (rc_b[b])
        );

        assign open_row_o[b*ADDR_W +: ADDR_W] = row_q;
    end

    logic            mrd_busy, rrd_busy, ap_busy;
    logic [BA_W-1:0] last_ba;

    sdrmon_track #(
        .BA_W      (BA_W),
        .CW        (CW),
        .T_MRD     (T_MRD),
        .T_RRD     (T_RRD),
        .BURST_LEN (BURST_LEN)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrs_i      (is_mrs),
        .act_i      (is_act),
        .ap_i       (is_rdwr && ap_bit),
        .ba_i       (ba),
        .mrd_busy_o (mrd_busy),
        .rrd_busy_o (rrd_busy),
        .ap_busy_o  (ap_busy),
        .last_ba_o  (last_ba)
    );

    logic [NUM_ERR-1:0] err_now;
    logic [3:0]         first_now;

    // Rule evaluation against the state before this command; bit k-1 is code k.
    always_comb begin
        err_now = '0;
        err_now[ERR_MRD-1]    = mrd_busy && is_live;
        err_now[ERR_IDLE-1]   = (is_mrs || is_ref) && (|open_v);
        err_now[ERR_RCD-1]    = is_rdwr && rcd_b[ba];
        err_now[ERR_RAS-1]    = is_pre && (ap_bit ? |(open_v & ras_b)
                                                  : (open_v[ba] && ras_b[ba]));
        err_now[ERR_RP-1]     = is_act && rp_b[ba];
        err_now[ERR_RC-1]     = is_act && rc_b[ba];
        err_now[ERR_RRD-1]    = is_act && rrd_busy && (ba != last_ba);
        err_now[ERR_APBUSY-1] = is_rdwr && ap_busy;
        err_now[ERR_CLOSED-1] = (is_rdwr || (is_pre && !ap_bit)) && !open_v[ba];
        err_now[ERR_REOPEN-1] = is_act && open_v[ba];
    end

    // Lowest raised code wins when several rules break together.
    always_comb begin
        first_now = ERR_NONE;
        for (int k = NUM_ERR - 1; k >= 0; k--) begin
            if (err_now[k])
                first_now = 4'(k + 1);
        end
    end

    // Registered command view and sticky error record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o       <= CMD_DESEL;
            err_flags_o <= '0;
            err_first_o <= ERR_NONE;
        end else begin
            cmd_o       <= cmd;
            err_flags_o <= err_flags_o | err_now;
            if (err_first_o == ERR_NONE)
                err_first_o <= first_now;
        end
    end

    assign bank_open_o = open_v;

endmodule

// File: rtl/sdrmon_checker.sv
// Property checker for sdr_cmd_monitor, attached by bind.
// Decodes the pins on its own and relates them to the monitor's outputs one
// edge later. Assumes T_MRD of at least 2 for the settle-window property.
module sdrmon_checker #(
    parameter int BA_W    = 2,
    parameter int ADDR_W  = 12,
    parameter int AP_BIT  = 10,
    parameter int T_MRD   = 2,
    parameter int NUM_ERR = 10,
    localparam int NB     = 1 << BA_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cke,
    input logic               cs_n,
    input logic               ras_n,
    input logic               cas_n,
    input logic               we_n,
    input logic [BA_W-1:0]    ba,
    input logic [ADDR_W-1:0]  addr,
    input logic [NB-1:0]      bank_open_o,
    input logic [NUM_ERR-1:0] err_flags_o,
    input logic [3:0]         err_first_o
);

    logic sel, c_mrs, c_ref, c_pre_all, c_act, c_any;

    assign sel       = cke && !cs_n;
    assign c_mrs     = sel && ({ras_n, cas_n, we_n} == 3'b000);
    assign c_ref     = sel && ({ras_n, cas_n, we_n} == 3'b001);
    assign c_pre_all = sel && ({ras_n, cas_n, we_n} == 3'b010) && addr[AP_BIT];
    assign c_act     = sel && ({ras_n, cas_n, we_n} == 3'b011);
    assign c_any     = sel && ({ras_n, cas_n, we_n} != 3'b111);

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o))); // R4

    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_first_o != 4'd0) |=> (err_first_o == $past(err_first_o))); // R4

    AST_FIRST_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_first_o != 4'd0) |-> err_flags_o[4'(err_first_o - 4'd1)]); // R4

    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        c_pre_all |=> (bank_open_o == '0)); // R2

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        c_act |=> bank_open_o[$past(ba)]); // R2

    AST_REOPEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_act && bank_open_o[ba]) |=> err_flags_o[9]); // R13

    AST_IDLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_mrs || c_ref) && (|bank_open_o)) |=> err_flags_o[1]); // R6

    AST_MRD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((T_MRD >= 2) && $past(rst_n) && $past(c_mrs) && c_any) |=> err_flags_o[0]); // R5

endmodule

bind sdr_cmd_monitor sdrmon_checker #(
    .BA_W    (BA_W),
    .ADDR_W  (ADDR_W),
    .AP_BIT  (AP_BIT),
    .T_MRD   (T_MRD),
    .NUM_ERR (sdrmon_pkg::NUM_ERR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr        (addr),
    .bank_open_o (bank_open_o),
    .err_flags_o (err_flags_o),
    .err_first_o (err_first_o)
);

// File: tb/sdr_cmd_monitor_bench.sv
// Bench for sdr_cmd_monitor: a behavioural model built on absolute cycle
// stamps, compared with every output on every falling edge.
module sdr_cmd_monitor_bench;

    localparam int T_MRD = 2, T_RCD = 2, T_RAS = 5, T_RP = 2, T_RC = 7;
    localparam int T_RRD = 2, BL = 4;
    localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010,
                           P_ACT = 3'b011, P_WR = 3'b100, P_RD = 3'b101,
                           P_BST = 3'b110, P_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b0;
    logic [2:0]  rcw = P_NOP;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;

    logic [3:0]  cmd_o;
    logic [3:0]  bank_open_o;
    logic [47:0] open_row_o;
    logic [9:0]  err_flags_o;
    logic [3:0]  err_first_o;

    int checks = 0, errors = 0;
    bit done = 0, seen_edge = 0;

    always #10 clk = ~clk;

    sdr_cmd_monitor u_sdr_cmd_monitor (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
        .ras_n (rcw[2]), .cas_n (rcw[1]), .we_n (rcw[0]),
        .ba (ba), .addr (addr), .cmd_o (cmd_o), .bank_open_o (bank_open_o),
        .open_row_o (open_row_o), .err_flags_o (err_flags_o),
        .err_first_o (err_first_o)
    );

    // Reference model state.
    int          now_c, mrs_t, last_act_t, ap_ok, last_ba;
    int          act_t [4];
    int          rp_ok [4];
    bit          m_open [4];
    logic [11:0] m_row [4];
    logic [3:0]  m_cmd, m_first;
    logic [9:0]  m_flags;

    function automatic string req_of(int k);
        case (k)
            0: return "R5";  1: return "R6";  2: return "R7";  3: return "R8";
            4: return "R9";  5: return "R10"; 6: return "R11"; 7: return "R12";
            default: return "R13";
        endcase
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        seen_edge <= 1;
        if (!rst_n) begin
            now_c = 0; mrs_t = -1000; last_act_t = -1000; ap_ok = 0; last_ba = 0;
            for (int b = 0; b < 4; b++) begin
                act_t[b] = -1000; rp_ok[b] = 0; m_open[b] = 0; m_row[b] = '0;
            end
            m_cmd = 0; m_first = 0; m_flags = '0;
        end else begin
            int c, bb;
            bit ap, any_open, rdwr;
            bit e [10];
            bb = int'(ba); ap = addr[10];
            if (!cke || cs_n) c = 0;
            else case (rcw)
                P_MRS: c = 2; P_REF: c = 3; P_PRE: c = 4; P_ACT: c = 5;
                P_WR:  c = 6; P_RD:  c = 7; P_BST: c = 8; default: c = 1;
            endcase
            rdwr = (c == 6 || c == 7);
            any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
            e[0] = (c > 1) && (now_c - mrs_t < T_MRD);
            e[1] = (c == 2 || c == 3) && any_open;
            e[2] = rdwr && (now_c - act_t[bb] < T_RCD);
            e[3] = 0;
            if (c == 4) begin
                for (int b = 0; b < 4; b++)
                    if ((ap || b == bb) && m_open[b] && (now_c - act_t[b] < T_RAS)) e[3] = 1;
            end
            e[4] = (c == 5) && (now_c < rp_ok[bb]);
            e[5] = (c == 5) && (now_c - act_t[bb] < T_RC);
            e[6] = (c == 5) && (bb != last_ba) && (now_c - last_act_t < T_RRD);
            e[7] = rdwr && (now_c < ap_ok);
            e[8] = (rdwr || (c == 4 && !ap)) && !m_open[bb];
            e[9] = (c == 5) && m_open[bb];
            if (c == 2) mrs_t = now_c;
            if (c == 5) begin
                m_open[bb] = 1; m_row[bb] = addr; act_t[bb] = now_c;
                last_act_t = now_c; last_ba = bb;
            end
            if (c == 4) begin
                for (int b = 0; b < 4; b++)
                    if (ap || b == bb) begin m_open[b] = 0; rp_ok[b] = now_c + T_RP; end
            end
            if (rdwr && ap) begin
                ap_ok = now_c + BL; m_open[bb] = 0; rp_ok[bb] = now_c + BL + T_RP;
            end
            for (int k = 9; k >= 0; k--) begin
                if (e[k]) begin
                    m_flags[k] = 1'b1;
                end
            end
            if (m_first == 0) begin
                for (int k = 9; k >= 0; k--) if (e[k]) m_first = 4'(k + 1);
            end
            m_cmd = 4'(c);
            now_c = now_c + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            logic [3:0] eo;
            eo = {m_open[3], m_open[2], m_open[1], m_open[0]};
            check(cmd_o == m_cmd, "R1", "cmd_o", 48'(cmd_o), 48'(m_cmd));
            check(bank_open_o == eo, "R2", "bank_open_o", 48'(bank_open_o), 48'(eo));
            for (int b = 0; b < 4; b++)
                check(open_row_o[b*12 +: 12] == m_row[b], "R3", "open_row_o",
                      48'(open_row_o[b*12 +: 12]), 48'(m_row[b]));
            for (int k = 0; k < 10; k++)
                check(err_flags_o[k] == m_flags[k], req_of(k), "err_flags_o bit",
                      48'(err_flags_o[k]), 48'(m_flags[k]));
            check(err_first_o == m_first, "R4", "err_first_o", 48'(err_first_o), 48'(m_first));
        end
    end

    // One bus cycle: inputs change just after the falling edge.
    task automatic cyc(input logic [2:0] p, input int b = 0, input logic ap = 0,
                       input logic [11:0] row = 12'h000, input logic csn = 0,
                       input logic ck = 1);
        @(negedge clk);
        #2;
        rcw = p; ba = 2'(b); cs_n = csn; cke = ck;
        addr = ap ? (row | 12'h400) : (row & 12'hBFF);
    endtask

    initial begin
        repeat (3) cyc(P_NOP);
        @(negedge clk); #2 rst_n = 1'b1;
        // R1, R2, R3: legal sequence
        cyc(P_NOP); cyc(P_MRS); cyc(P_NOP); cyc(P_NOP);
        cyc(P_ACT, 0, 0, 12'h123); cyc(P_NOP); cyc(P_RD, 0); cyc(P_NOP); cyc(P_NOP);
        cyc(P_PRE, 0); cyc(P_NOP);
        // R1: deselected and clock-disabled cycles carry no command
        cyc(P_ACT, 1, 0, 12'h777, 1); cyc(P_REF, 0, 0, 12'h0, 0, 0); cyc(P_NOP); cyc(P_NOP);
        // R7, R8, R9, R10, R11, R13: back-to-back violations
        cyc(P_ACT, 1, 0, 12'h0AA); cyc(P_RD, 1); cyc(P_PRE, 1); cyc(P_ACT, 1, 0, 12'h0AB);
        cyc(P_ACT, 2, 0, 12'h3C3); cyc(P_ACT, 2, 0, 12'h3C4);
        cyc(P_PRE, 3); cyc(P_RD, 3); repeat (3) cyc(P_NOP);
        // R4: reset clears the sticky record
        @(negedge clk); #2 rst_n = 1'b0; cyc(P_NOP); cyc(P_NOP);
        @(negedge clk); #2 rst_n = 1'b1;
        // R12, R9 via auto-precharge, R6, R5, R8 with all-bank precharge
        cyc(P_ACT, 0, 0, 12'h055); cyc(P_NOP); cyc(P_WR, 0, 1); cyc(P_WR, 1);
        cyc(P_NOP); cyc(P_ACT, 0, 0, 12'h056); repeat (7) cyc(P_NOP);
        cyc(P_ACT, 3, 0, 12'h2F0); cyc(P_NOP); cyc(P_REF); cyc(P_MRS);
        cyc(P_ACT, 1, 0, 12'h011); cyc(P_NOP); cyc(P_NOP);
        cyc(P_PRE, 2, 1); cyc(P_BST); repeat (3) cyc(P_NOP);
        @(negedge clk);
        done = 1;
    end

    initial begin
        repeat (100000) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        #5;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule